// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns eight external pin signals into interrupt requests. Each pin has a 2-bit sense code that picks the trigger condition: low level, any change, falling edge or rising edge. Software sets the codes, a per-pin enable mask and a per-pin event flag register through a small synchronous register port. A global interrupt-enable input gates every request. Per-pin acknowledge inputs let an interrupt controller retire a latched event.

The upper four pins are fully clocked. Each passes through a two-stage synchronizer, and an edge is detected by comparing the present sample with the one taken a cycle earlier. The lower four pins catch edges without the clock. A pin-driven capture flop toggles on the selected edge, and the toggle is carried into the clock domain. On these pins, code 01 is reserved and never raises anything. Edge events latch into sticky flags. Level requests are not latched: they follow the synchronized pin.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every register reads 0 (each pin in low-level mode, mask clear, flags clear), and `irq_o` is 0.
- R2: Register map: address 0 holds the codes for pins 3..0 and address 1 holds those for pins 7..4. Pin k uses bits [2*(k mod 4)+1 : 2*(k mod 4)]. Address 2 is the mask (bit k = pin k). Address 3 is the flag register. It reads the flags, and writing 1 to a bit clears that flag. Writes occur on the clock edge, and reads are combinational on the address.
- R3: On pins 7..4, the codes mean: 00 = request while low, 01 = event on any change, 10 = event on a falling transition between two samples, 11 = event on a rising transition between two samples.
- R4: On pins 3..0, code 00 is low level, 10 captures a falling edge and 11 captures a rising edge. Edges are captured even when the pulse falls entirely between two clock edges. Code 01 never raises a request.
- R5: In low-level mode the request is asserted while the synchronized pin is low and drops when the pin returns high. No flag is set.
- R6: Output `req_o[k]` = (flag k OR level request k) AND mask bit k AND `gie_i`. `irq_o` is the OR of all of `req_o`.
- R7: On pins 7..4, a pulse longer than one clock period sets the flag in edge and change modes.
- R8: A flag is cleared by its `ack_i` bit or by a write of 1 to its bit at address 3. Otherwise it holds.
- R9: When an event and a clear reach the same flag in the same cycle, the flag ends set.
- R10: Changing a code while the pin is unmasked can raise a spurious request. Masking the pin, changing the code, clearing the flag and then unmasking raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | External interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 8 | Per-pin flag acknowledge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| req_o | output | 8 | Per-pin gated requests |
| irq_o | output | 1 | OR of all requests |

## Verification
An edge event setting a flag and an acknowledge clearing that same flag can land on one clock edge. The bench flips an upper pin in any-change mode. It then counts the two synchronizer stages and asserts the acknowledge in exactly the cycle whose closing edge loads the flag. A flag still set at the next read shows that the event won. A following lone acknowledge must then clear the flag, which proves the clear path works on its own.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // event from two successive clocked samples
  function automatic logic sampled_event(input logic [1:0] code,
                                         input logic prv, input logic cur);
    logic hit;
    case (code)
      SENSE_ANY:  hit = prv ^ cur;
      SENSE_FALL: hit = prv & ~cur;
      SENSE_RISE: hit = ~prv & cur;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

  // level request condition
  function automatic logic level_hit(input logic [1:0] code, input logic cur);
    return (code == SENSE_LOW) && !cur;
  endfunction

  // whether an event may set the flag under this code
  function automatic logic edge_armed(input logic [1:0] code, input logic async_grp);
    return async_grp ? code[1] : (code != SENSE_LOW);
  endfunction

  // capture clock for the unclocked group: pin for rise, inverted pin for fall, 0 otherwise
  function automatic logic capture_clk(input logic [1:0] code, input logic pin);
    return code[1] & (pin ~^ code[0]);
  endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st[s] <= '0;
      else if (s == 0) st[s] <= d;
      else             st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/eis_regs.sv
module eis_regs #(
  parameter int N_PINS = 8,
  parameter int DW     = 8,
  parameter int AW     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [N_PINS-1:0]       flags_i,
  output logic [2*N_PINS-1:0]     codes_o,
  output logic [N_PINS-1:0]       mask_o,
  output logic [N_PINS-1:0]       w1c_o,
  output logic [DW-1:0]           rdata_o
);
  localparam int FPR       = DW / 2;
  localparam int CTRL_REGS = N_PINS / FPR;
  localparam int MASK_ADDR = CTRL_REGS;
  localparam int FLAG_ADDR = CTRL_REGS + 1;

  logic [DW-1:0]     ctrl_q [CTRL_REGS];
  logic [N_PINS-1:0] mask_q;

  for (genvar r = 0; r < CTRL_REGS; r++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  ctrl_q[r] <= '0;
      else if (we_i && addr_i == AW'(r))           ctrl_q[r] <= wdata_i;
    end
    assign codes_o[r*DW +: DW] = ctrl_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mask_q <= '0;
    else if (we_i && addr_i == AW'(MASK_ADDR)) mask_q <= wdata_i[N_PINS-1:0];
  end
  assign mask_o = mask_q;

  assign w1c_o = (we_i && addr_i == AW'(FLAG_ADDR)) ? wdata_i[N_PINS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < CTRL_REGS; r++)
      if (addr_i == AW'(r)) rdata_o = ctrl_q[r];
    if (addr_i == AW'(MASK_ADDR)) rdata_o = DW'(mask_q);
    if (addr_i == AW'(FLAG_ADDR)) rdata_o = DW'(flags_i);
  end
endmodule

// File: rtl/eis_pin.sv
module eis_pin import eis_pkg::*; #(
  parameter bit ASYNC = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] code_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       level_o
);
  logic cur_lvl;
  logic evt;
  logic set_en;
  logic flag_q;

  if (ASYNC) begin : g_async
    logic       edge_clk;
    logic       tog_q;
    logic       prev_q;
    logic [1:0] sq;
    assign edge_clk = capture_clk(code_i, pin_i);
    always_ff @(posedge edge_clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= ~tog_q;
    end
    eis_sync #(.W(2), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({tog_q, pin_i}), .q(sq)
    );
    assign cur_lvl = sq[0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sq[1];
    end
    assign evt = sq[1] ^ prev_q;
  end else begin : g_clocked
    logic prev_q;
    eis_sync #(.W(1), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(cur_lvl)
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur_lvl;
    end
    assign evt = sampled_event(code_i, prev_q, cur_lvl);
  end

  assign set_en = evt & edge_armed(code_i, ASYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_en) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o  = flag_q;
  assign level_o = level_hit(code_i, cur_lvl);

  // R9: event wins over a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> flag_q);
  // R8: clear without event empties the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_en) |=> !flag_q);
  // R8: flag holds without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R5: level mode never sets a flag
  p_level_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 2'b00 && !flag_q) |=> !flag_q);

  if (ASYNC) begin : g_resv_chk
    // R4: reserved code on the unclocked group stays silent
    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == 2'b01 && !flag_q) |=> !flag_q);
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int N_PINS  = 8,
  parameter int N_ASYNC = 4,
  parameter int DW      = 8,
  parameter int AW      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              gie_i,
  input  logic [N_PINS-1:0] ack_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [N_PINS-1:0] req_o,
  output logic              irq_o
);
  logic [2*N_PINS-1:0] codes;
  logic [N_PINS-1:0]   mask;
  logic [N_PINS-1:0]   w1c;
  logic [N_PINS-1:0]   flags;
  logic [N_PINS-1:0]   level_req;
  logic [N_PINS-1:0]   clr;

  eis_regs #(.N_PINS(N_PINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .flags_i(flags), .codes_o(codes),
    .mask_o(mask), .w1c_o(w1c), .rdata_o(reg_rdata_o)
  );

  assign clr = w1c | ack_i;

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    eis_pin #(.ASYNC(k < N_ASYNC)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i[k]), .code_i(codes[2*k +: 2]),
      .clr_i(clr[k]), .flag_o(flags[k]), .level_o(level_req[k])
    );
  end

  assign req_o = (flags | level_req) & mask & {N_PINS{gie_i}};
  assign irq_o = |req_o;

  // R6: no request without the global enable
  p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (req_o == '0 && !irq_o));
  // R6: no request on a masked pin
  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & ~mask) == '0);
endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin;
  logic       gie;
  logic [7:0] ack;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] req;
  logic       irq;

  int tests = 0;
  int fails = 0;
  logic [7:0] ctl [2];

  always #4 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .gie_i(gie), .ack_i(ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .req_o(req), .irq_o(irq)
  );

  typedef struct packed {
    logic [2:0] pin;
    logic [1:0] code;
    logic       l0;
    logic       l1;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [0:12] = '{
    '{3'd5, 2'b00, 1'b1, 1'b0, 1'b1},  // R3 level low
    '{3'd5, 2'b00, 1'b0, 1'b1, 1'b0},  // R3 level high
    '{3'd5, 2'b01, 1'b0, 1'b1, 1'b1},  // R3 any change up
    '{3'd5, 2'b01, 1'b1, 1'b0, 1'b1},  // R3 any change down
    '{3'd6, 2'b10, 1'b1, 1'b0, 1'b1},  // R3 fall
    '{3'd6, 2'b10, 1'b0, 1'b1, 1'b0},  // R3 rise on fall mode
    '{3'd7, 2'b11, 1'b0, 1'b1, 1'b1},  // R3 rise
    '{3'd7, 2'b11, 1'b1, 1'b0, 1'b0},  // R3 fall on rise mode
    '{3'd0, 2'b01, 1'b0, 1'b1, 1'b0},  // R4 reserved
    '{3'd2, 2'b10, 1'b1, 1'b0, 1'b1},  // R4 fall
    '{3'd2, 2'b11, 1'b1, 1'b0, 1'b0},  // R4 fall on rise mode
    '{3'd2, 2'b11, 1'b0, 1'b1, 1'b1},  // R4 rise
    '{3'd3, 2'b00, 1'b1, 1'b0, 1'b1}   // R4 level low
  };

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_code(input int p, input logic [1:0] c);
    ctl[p/4][2*(p%4) +: 2] = c;
    wr(2'(p/4), ctl[p/4]);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; pin = 8'hFF; gie = 1'b0; ack = '0;
    we = 1'b0; addr = '0; wdata = '0;
    ctl[0] = '0; ctl[1] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg", d, 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 readback
    wr(2'd1, 8'hB4); rd(2'd1, d); check("R2 ctrl hi", d, 8'hB4);
    wr(2'd2, 8'h5A); rd(2'd2, d); check("R2 mask", d, 8'h5A);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    tick(4);
    wr(2'd3, 8'hFF);

    // vector table: R3 and R4
    gie = 1'b1;
    for (int i = 0; i < 13; i++) begin
      wr(2'd2, 8'h00);
      pin[VEC[i].pin] = VEC[i].l0;
      set_code(int'(VEC[i].pin), VEC[i].code);
      tick(5);
      wr(2'd3, 8'hFF);
      wr(2'd2, 8'(1) << VEC[i].pin);
      pin[VEC[i].pin] = VEC[i].l1;
      tick(5);
      check((VEC[i].pin >= 3'd4) ? "R3 vector" : "R4 vector",
            {7'd0, req[VEC[i].pin]}, {7'd0, VEC[i].exp});
      pin[VEC[i].pin] = 1'b1;
      tick(4);
    end
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);

    // R5 level follows pin, no flag
    set_code(5, 2'b00);
    wr(2'd2, 8'h20);
    pin[5] = 1'b0; tick(4);
    check("R5 level on", {7'd0, req[5]}, 8'h01);
    pin[5] = 1'b1; tick(4);
    check("R5 level drop", {7'd0, req[5]}, 8'h00);
    rd(2'd3, d); check("R5 no flag", d, 8'h00);

    // R6 global enable gate
    set_code(7, 2'b00);
    wr(2'd2, 8'h80);
    gie = 1'b0; pin[7] = 1'b0; tick(4);
    check("R6 gie off", {req, irq} , 9'h000);
    gie = 1'b1; tick(1);
    check("R6 gie on", {req[7], irq} , 2'b11);
    pin[7] = 1'b1; tick(4);
    wr(2'd2, 8'h00);

    // R7 pulse of 1.5 clock periods on a clocked pin
    set_code(6, 2'b10);
    tick(4); wr(2'd3, 8'hFF); wr(2'd2, 8'h40);
    @(negedge clk); pin[6] = 1'b0; #12 pin[6] = 1'b1;
    tick(5);
    check("R7 pulse", {7'd0, req[6]}, 8'h01);
    wr(2'd2, 8'h00); wr(2'd3, 8'hFF);

    // R4 sub-period pulse on an unclocked pin
    set_code(0, 2'b10);
    tick(5); wr(2'd3, 8'hFF);
    @(negedge clk); #1 pin[0] = 1'b0; #1 pin[0] = 1'b1;
    tick(5);
    rd(2'd3, d); check("R4 short pulse", d & 8'h01, 8'h01);
    wr(2'd3, 8'hFF);

    // R9 event and ack in the same cycle
    set_code(4, 2'b01);
    tick(5); wr(2'd3, 8'hFF); wr(2'd2, 8'h10);
    @(negedge clk); pin[4] = ~pin[4];
    @(negedge clk);
    @(negedge clk); ack[4] = 1'b1;
    @(negedge clk); ack[4] = 1'b0;
    rd(2'd3, d); check("R9 set wins", d & 8'h10, 8'h10);
    // R8 lone ack clears
    @(negedge clk); ack[4] = 1'b1;
    @(negedge clk); ack[4] = 1'b0;
    rd(2'd3, d); check("R8 ack clear", d & 8'h10, 8'h00);
    // R8 write-one clear
    pin[4] = ~pin[4]; tick(5);
    rd(2'd3, d); check("R8 flag set", d & 8'h10, 8'h10);
    wr(2'd3, 8'h10);
    rd(2'd3, d); check("R8 w1c", d & 8'h10, 8'h00);
    wr(2'd2, 8'h00);

    // R10 spurious request on unmasked code change
    pin[1] = 1'b1;
    set_code(1, 2'b00);
    tick(5); wr(2'd3, 8'hFF);
    wr(2'd2, 8'h02); tick(2);
    check("R10 idle", {7'd0, req[1]}, 8'h00);
    set_code(1, 2'b11); tick(5);
    check("R10 spurious", {7'd0, req[1]}, 8'h01);
    // R10 safe sequence
    wr(2'd2, 8'h00);
    set_code(1, 2'b00);
    set_code(1, 2'b11);
    tick(5);
    wr(2'd3, 8'hFF);
    wr(2'd2, 8'h02); tick(3);
    check("R10 safe", {7'd0, req[1]}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule